// File: doc/BRIEF.md
# Incremental Converter Decimation Filter

This block turns the stream of signed quantizer codes from an incremental sigma-delta modulator into one result word per conversion. It passes every code through a chain of ORDER accumulators, one per order of the modulator, so that the chain mirrors the modulator's noise transfer function (1 - z^-1)^ORDER. Unlike a free-running decimator, the chain is wiped at the start of each conversion. A result therefore depends only on the samples of its own conversion.

A one-cycle `start_i` pulse begins a conversion. The code presented in that same cycle is the first sample. The conversion length (the oversampling ratio) is read from `osr_i` in that first cycle. Once that many samples have been taken, the block emits the final sum on `dout_o` with a one-cycle `valid_o` strobe. It then begins the next conversion on the following cycle without needing another pulse. A fresh `start_i` at any time abandons the conversion in progress and starts over.

Top module: `incr_decim`

## Requirements
- R1: After reset, `valid_o` and `dout_o` are 0, and `valid_o` stays 0 on every cycle until the first `start_i` has been sampled.
- R2: The code sampled in the cycle where `start_i` is high is the first sample of a new conversion. Nothing accumulated before that cycle contributes to the new result.
- R3: For a conversion of K samples, `valid_o` is high for exactly one cycle, on the cycle after the edge that samples the K-th code. The next conversion starts with the following sample, without a new `start_i`.
- R4: The length K is taken from `osr_i` in the first cycle of each conversion. Changes to `osr_i` during the rest of the conversion have no effect on its length or its result.
- R5: With ORDER = 1, the result is the plain sum of the K two's-complement codes of the conversion. For a code of 0 or 1, this is a count of ones and takes K+1 distinct values.
- R6: With ORDER = 2, sample i (counting from 1) of a K-sample conversion is weighted by K-i+1. The first sample weighs K and the last weighs 1. In general the weight is the binomial C(K-i+ORDER-1, ORDER-1).
- R7: An `osr_i` of 1 gives a one-sample conversion: the result equals the code itself and `valid_o` follows one cycle later. An `osr_i` of 0 is treated as 1.
- R8: A `start_i` in the middle of a conversion abandons it: no `valid_o` is produced for the partial conversion, and the new conversion's result ignores the abandoned samples.
- R9: `dout_o` holds its value on every cycle where `valid_o` is low.
- R10: The accumulators are ACC_W = CODE_W + ORDER*OSR_W bits wide, so results stay exact for full-scale positive and negative codes at the largest ratio, 2^OSR_W - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock; one code per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a new conversion with this cycle's code |
| osr_i | input | OSR_W | Samples per conversion, read in the first cycle (0 means 1) |
| code_i | input | CODE_W | Signed two's-complement quantizer code |
| dout_o | output | ACC_W | Signed conversion result, held between strobes |
| valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench builds two copies of the filter from the same stimulus: ORDER = 2 and ORDER = 1, both with CODE_W = 3 and OSR_W = 4. The 4-bit ratio field makes the largest ratio, 15, cheap to reach. Full-scale codes of -4 and +3 at that ratio therefore exercise the accumulator width bound. Running the first-order copy alongside shows the flat weighting and the count-of-ones behaviour next to the descending ramp of the second-order copy. The ratios covered are 0, 1, 5, 7, 15 and a mid-conversion change of `osr_i`.

// File: rtl/incr_decim_pkg.sv
// Shared types for the incremental decimation filter.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package incr_decim_pkg;

    // Per-cycle control issued by the sequencer to the accumulator chain.
    typedef struct packed {
        logic take;   // a code is consumed this cycle
        logic first;  // this code opens a conversion (accumulators restart)
        logic last;   // this code closes a conversion
    } seq_ctl_t;

endpackage

// File: rtl/incr_decim_seq.sv
// Conversion sequencer: counts samples and marks the first and last sample of
// each conversion. The ratio is latched in the first cycle; a value of 0 is
// treated as 1. Assumes start_i is a single-cycle pulse, though a held level
// simply restarts every cycle.
module incr_decim_seq #(
    parameter int OSR_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [OSR_W-1:0]            osr_i,
    output incr_decim_pkg::seq_ctl_t    ctl_o
);
    logic             active_q;
    logic [OSR_W-1:0] cnt_q;
    logic [OSR_W-1:0] osr_q;
    logic [OSR_W-1:0] osr_eff;
    logic [OSR_W-1:0] len;
    logic [OSR_W-1:0] cnt_nx;
    logic             take;
    logic             first;
    logic             last;

    // Decode this cycle's sample role from the count and the start pulse.
    always_comb begin
        osr_eff = (osr_i == '0) ? {{(OSR_W-1){1'b0}}, 1'b1} : osr_i;
        take    = start_i | active_q;
        first   = start_i | (cnt_q == '0);
        len     = first ? osr_eff : osr_q;
        cnt_nx  = first ? {{(OSR_W-1){1'b0}}, 1'b1} : cnt_q + 1'b1;
        last    = take & (cnt_nx == len);
        ctl_o   = '{take: take, first: first, last: last};
    end

    // Track the running sample count, the latched ratio and the active flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            osr_q    <= '0;
        end else begin
            if (start_i) begin
                active_q <= 1'b1;
            end
            if (take) begin
                cnt_q <= last ? '0 : cnt_nx;
                if (first) begin
                    osr_q <= osr_eff;
                end
            end
        end
    end
endmodule

// File: rtl/incr_decim_stage.sv
// One accumulator of the cascade. sum_o is the value after adding this
// cycle's input; on the opening sample of a conversion the old state is
// dropped, so the stage restarts from its input. Assumes din_i is already
// sign-extended to ACC_W.
module incr_decim_stage #(
    parameter int ACC_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take_i,
    input  logic                    first_i,
    input  logic signed [ACC_W-1:0] din_i,
    output logic signed [ACC_W-1:0] sum_o
);
    logic signed [ACC_W-1:0] acc_q;

    // Next accumulator value, restarting on the first sample.
    always_comb begin
        sum_o = din_i + (first_i ? '0 : acc_q);
    end

    // Store the running sum whenever a sample is consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (take_i) begin
            acc_q <= sum_o;
        end
    end
endmodule

// File: rtl/incr_decim.sv
// Resetting decimation filter for an incremental sigma-delta converter.
// A cascade of ORDER accumulators restarts at each conversion; after the
// latched number of samples the final stage's sum is registered on dout_o
// with a one-cycle valid_o. Assumes one two's-complement code per clock.
module incr_decim #(
    parameter int ORDER  = 2,
    parameter int CODE_W = 3,
    parameter int OSR_W  = 8,
    parameter int ACC_W  = CODE_W + ORDER * OSR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [OSR_W-1:0]        osr_i,
    input  logic signed [CODE_W-1:0] code_i,
    output logic signed [ACC_W-1:0] dout_o,
    output logic                    valid_o
);
    localparam int EXT_W = ACC_W - CODE_W;

    incr_decim_pkg::seq_ctl_t ctl;
    logic signed [ACC_W-1:0]  chain [ORDER+1];

    // Sample sequencing.
    incr_decim_seq #(.OSR_W(OSR_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .osr_i   (osr_i),
        .ctl_o   (ctl)
    );

    // Sign-extend the incoming code into the head of the chain.
    always_comb begin
        chain[0] = {{EXT_W{code_i[CODE_W-1]}}, code_i};
    end

    // One accumulator per order, each fed by the previous stage's new sum.
    for (genvar k = 0; k < ORDER; k++) begin : g_stage
        incr_decim_stage #(.ACC_W(ACC_W)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .take_i  (ctl.take),
            .first_i (ctl.first),
            .din_i   (chain[k]),
            .sum_o   (chain[k+1])
        );
    end

    // Register the result and strobe once per completed conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= ctl.last;
            if (ctl.last) begin
                dout_o <= chain[ORDER];
            end
        end
    end
endmodule

// File: rtl/incr_decim_chk.sv
// Port-level properties of the decimation filter, bound to every instance.
module incr_decim_chk #(
    parameter int CODE_W = 3,
    parameter int OSR_W  = 8,
    parameter int ACC_W  = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start_i,
    input logic [OSR_W-1:0]         osr_i,
    input logic signed [CODE_W-1:0] code_i,
    input logic signed [ACC_W-1:0]  dout_o,
    input logic                     valid_o
);
    logic                    seen_q;
    logic signed [ACC_W-1:0] code_ext;

    // Remember whether any conversion has been requested since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else if (start_i) seen_q <= 1'b1;
    end

    // Reference sign extension of the incoming code.
    always_comb code_ext = ACC_W'(code_i);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !valid_o); // R1
    AST_SINGLE_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && osr_i <= 1) |=> (valid_o && dout_o == $past(code_ext))); // R7
    AST_RESTART_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && osr_i > 1) |=> !valid_o); // R8
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(dout_o)); // R9
endmodule

bind incr_decim incr_decim_chk #(
    .CODE_W (CODE_W),
    .OSR_W  (OSR_W),
    .ACC_W  (ACC_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .osr_i   (osr_i),
    .code_i  (code_i),
    .dout_o  (dout_o),
    .valid_o (valid_o)
);

// File: tb/incr_decim_bench.sv
// Bench: behavioural reference (queue of samples, weighted sums) compared
// against an ORDER=2 and an ORDER=1 filter on every clock.
module incr_decim_bench;
    localparam int CODE_W = 3;
    localparam int OSR_W  = 4;
    localparam int W2     = CODE_W + 2 * OSR_W;
    localparam int W1     = CODE_W + 1 * OSR_W;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     start = 1'b0;
    logic [OSR_W-1:0]         osr = '0;
    logic signed [CODE_W-1:0] code = '0;
    logic signed [W2-1:0]     dout2;
    logic signed [W1-1:0]     dout1;
    logic                     valid2;
    logic                     valid1;

    int    vectors = 0;
    int    fails = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // Reference model state.
    int m_active = 0;
    int m_cnt = 0;
    int m_osr = 1;
    int q[$];
    int exp_v = 0;
    int exp1 = 0;
    int exp2 = 0;

    always #10 clk = ~clk;

    incr_decim #(.ORDER(2), .CODE_W(CODE_W), .OSR_W(OSR_W)) u_incr_decim (
        .clk(clk), .rst_n(rst_n), .start_i(start), .osr_i(osr),
        .code_i(code), .dout_o(dout2), .valid_o(valid2)
    );

    incr_decim #(.ORDER(1), .CODE_W(CODE_W), .OSR_W(OSR_W)) u_incr_decim_o1 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .osr_i(osr),
        .code_i(code), .dout_o(dout1), .valid_o(valid1)
    );

    // Reference update on each rising edge from the inputs set at the falling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_cnt = 0; exp_v = 0; exp1 = 0; exp2 = 0;
            q.delete();
        end else begin
            exp_v = 0;
            if (start || m_active != 0) begin
                if (start || m_cnt == 0) begin
                    q.delete();
                    m_osr = (osr == 0) ? 1 : int'(osr);
                end
                q.push_back(int'(code));
                m_cnt = q.size();
                if (m_cnt == m_osr) begin
                    exp1 = 0; exp2 = 0;
                    for (int i = 0; i < m_osr; i++) begin
                        exp1 += q[i];
                        exp2 += q[i] * (m_osr - i);
                    end
                    exp_v = 1;
                    m_cnt = 0;
                end
            end
            if (start) m_active = 1;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 200000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic compare();
        vectors++;
        if (valid2 !== (exp_v != 0) || int'(dout2) != exp2) begin
            fails++;
            $display("FAIL %s order2: actual valid=%0b dout=%0d, expected valid=%0d dout=%0d",
                     cur_req, valid2, int'(dout2), exp_v, exp2);
        end
        vectors++;
        if (valid1 !== (exp_v != 0) || int'(dout1) != exp1) begin
            fails++;
            $display("FAIL %s order1: actual valid=%0b dout=%0d, expected valid=%0d dout=%0d",
                     cur_req, valid1, int'(dout1), exp_v, exp1);
        end
    endtask

    // One cycle: check outputs away from the edge, then drive new inputs.
    task automatic cyc(input int c, input bit s, input int o);
        @(negedge clk);
        if (rst_n) compare();
        code  = c[CODE_W-1:0];
        start = s;
        osr   = o[OSR_W-1:0];
    endtask

    initial begin
        // R1: reset, then idle cycles with codes but no start.
        cyc(0, 0, 0); cyc(0, 0, 0);
        @(negedge clk); rst_n = 1'b1;
        cur_req = "R1";
        for (int i = 0; i < 4; i++) cyc(i - 2, 0, 7);

        // R2, R5, R6: binary codes at ratio 7 (count of ones / descending ramp).
        cur_req = "R5_R6";
        cyc(1, 1, 7);
        for (int i = 0; i < 6; i++) cyc((i % 3 == 0) ? 1 : 0, 0, 7);
        // R3: back-to-back conversion without start, signed codes.
        cur_req = "R3";
        for (int i = 0; i < 7; i++) cyc(i - 4, 0, 7);
        for (int i = 0; i < 7; i++) cyc(3 - i, 0, 7);

        // R4: ratio changes mid-conversion are ignored.
        cur_req = "R4";
        cyc(2, 1, 5);
        for (int i = 0; i < 4; i++) cyc(-1 - i, 0, 9 + i);
        cyc(1, 0, 9);

        // R7: one-sample conversions, explicit ratio 1 and ratio 0.
        cur_req = "R7";
        cyc(-3, 1, 1);
        for (int i = 0; i < 5; i++) cyc(i - 2, 0, 1);
        cyc(3, 1, 0);
        for (int i = 0; i < 3; i++) cyc(-4 + i, 0, 0);

        // R8: restart in the middle discards the partial conversion.
        cur_req = "R8";
        cyc(3, 1, 6);
        cyc(3, 0, 6); cyc(3, 0, 6);
        cyc(-2, 1, 4);
        for (int i = 0; i < 3; i++) cyc(i, 0, 4);

        // R10: full-scale codes at the largest ratio.
        cur_req = "R10";
        cyc(-4, 1, 15);
        for (int i = 0; i < 14; i++) cyc(-4, 0, 15);
        for (int i = 0; i < 15; i++) cyc(3, 0, 15);

        // R9: result holds while the next conversion runs (checked each cycle).
        cur_req = "R9";
        for (int i = 0; i < 6; i++) cyc(i % 2, 0, 2);
        cyc(0, 0, 2); cyc(0, 0, 2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule